// File: doc/BRIEF.md
# Bridge System Error Reporting Logic

This block sits in a two-port bus bridge and decides when the bridge drives its upstream active-low system error line. Several causes can raise that line:

- an error arriving on the downstream system error input, when forwarding is enabled;
- a target abort or a master abort seen by the posted-write engine;
- a posted write that keeps being retried until a retry budget runs out;
- a data parity error on a posted write that passes a set of qualification checks.

A single command-register enable gates every cause.

The block also holds two sticky status bits that software clears by writing one. The first records that a downstream system error was received. The second records that the bridge itself signaled a system error. The block contains a counter of posted-write delivery retries. When the counter reaches its limit (2^24 by default), the block tells the posted-write engine to discard the data. Configuration decode, the transaction engines and parity generation are outside the block.

Top module: `bridge_syserr_ctrl`

## Requirements
- R1: `syserr_n` can go low only in the cycle after a cycle in which `cmd_syserr_en` was 1. When `cmd_syserr_en` is 0, no cause drives it low.
- R2: A downstream error event is a high-to-low transition of `dn_syserr_n` between two consecutive clock edges. When such an event occurs with `brc_fwd_en` at 1, `syserr_n` is low in the following cycle. The first edge after reset treats the previous level as 1.
- R3: A downstream error event with `brc_fwd_en` at 1 sets `sts_rcvd_syserr` in the following cycle, whatever the value of `cmd_syserr_en`.
- R4: `sts_sig_syserr` is 1 in every cycle in which `syserr_n` is low.
- R5: A one-cycle `pw_tabort` or `pw_mabort` strobe drives `syserr_n` low in the following cycle.
- R6: `pw_retry` strobes are counted. The retry that brings the count to RETRY_LIMIT, with no `pw_done` in that cycle, raises `pw_discard` for one cycle and drives `syserr_n` low in the following cycle.
- R7: The retry count returns to zero on reset, on `pw_done`, and on a discard. `pw_done` takes priority over a retry that arrives in the same cycle.
- R8: A `perr_valid` strobe with `perr_kind` = 2'b01 (posted write) causes a system error only when all of these hold: `perr_on_tgt_bus`=1, `perr_on_init_bus`=0, `perr_self_tgt`=0, `cmd_perr_resp`=1 and `brc_perr_resp`=1.
- R9: A `perr_valid` strobe with `perr_kind` = 2'b00 (read), 2'b10 (delayed write) or 2'b11 never causes a system error, whatever the other parity inputs are.
- R10: Both status bits are sticky. A one-cycle `clr_rcvd` or `clr_sig` strobe clears its bit in the following cycle. When a clear and a new set fall in the same cycle, the bit stays set.
- R11: Reset is synchronous and active high. It leaves `syserr_n`=1, `pw_discard`=0 and both status bits at 0. After reset, `syserr_n` is low for exactly those cycles that follow a cycle with a qualified, enabled cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_syserr_en | input | 1 | Command register system error enable |
| cmd_perr_resp | input | 1 | Command register parity error response enable |
| brc_fwd_en | input | 1 | Bridge control forward-downstream-error enable |
| brc_perr_resp | input | 1 | Bridge control parity error response enable |
| dn_syserr_n | input | 1 | Downstream system error input, active low |
| pw_tabort | input | 1 | Posted write target abort strobe |
| pw_mabort | input | 1 | Posted write master abort strobe |
| pw_retry | input | 1 | Posted write delivery attempt retried |
| pw_done | input | 1 | Posted write completed |
| perr_valid | input | 1 | Data parity error report strobe |
| perr_kind | input | 2 | Transaction kind: 00 read, 01 posted write, 10 delayed write |
| perr_on_tgt_bus | input | 1 | Error seen on the target-side bus |
| perr_on_init_bus | input | 1 | Error seen on the initiator-side bus |
| perr_self_tgt | input | 1 | Bridge detected the error itself as target |
| clr_rcvd | input | 1 | Write-one-to-clear for the received status bit |
| clr_sig | input | 1 | Write-one-to-clear for the signaled status bit |
| syserr_n | output | 1 | Upstream system error output, active low, registered |
| pw_discard | output | 1 | Discard the posted write data (one-cycle pulse) |
| sts_rcvd_syserr | output | 1 | Sticky: downstream system error received |
| sts_sig_syserr | output | 1 | Sticky: system error signaled |

## Verification
Two pairs of functions can fall in the same cycle. A software clear can land in the same cycle that a new event sets the bit. A completing posted write can arrive together with the retry that would exhaust the budget. The bench drives both collisions on purpose: `clr_sig` and `clr_rcvd` together with a forwarded downstream error, and `pw_done` in the same cycle as the limit-reaching retry. A behavioural model judges every cycle. It expects the bit to remain set in the first collision, and it expects no discard, with the count restarting from zero, in the second.

// File: rtl/syserr_pkg.sv
package syserr_pkg;

  typedef enum logic [1:0] {
    XK_READ    = 2'b00,
    XK_POSTED  = 2'b01,
    XK_DELAYED = 2'b10,
    XK_RSVD    = 2'b11
  } xact_kind_e;

  typedef struct packed {
    logic fwd;
    logic tabort;
    logic mabort;
    logic discard;
    logic parity;
  } cause_t;

  localparam int NUM_STS = 2;
  localparam int STS_RCVD = 0;
  localparam int STS_SIG  = 1;

endpackage

// File: rtl/syserr_retry_ctr.sv
module syserr_retry_ctr #(
  parameter int RETRY_LIMIT = 2**24
) (
  input  logic clk,
  input  logic rst,
  input  logic retry_i,
  input  logic done_i,
  output logic exhaust_o
);
  localparam int CNT_W = $clog2(RETRY_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  // R6: the retry that reaches the limit exhausts the budget; done wins (R7)
  assign exhaust_o = retry_i && !done_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || done_i || exhaust_o) begin
      cnt_q <= '0;
    end else if (retry_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/syserr_perr_qual.sv
module syserr_perr_qual
  import syserr_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] kind_i,
  input  logic       on_tgt_i,
  input  logic       on_init_i,
  input  logic       self_tgt_i,
  input  logic       cmd_resp_i,
  input  logic       brc_resp_i,
  output logic       hit_o
);
  logic is_posted;
  logic bus_ok;
  logic resp_ok;

  always_comb begin
    is_posted = (xact_kind_e'(kind_i) == XK_POSTED);      // R9
    bus_ok    = on_tgt_i && !on_init_i && !self_tgt_i;    // R8
    resp_ok   = cmd_resp_i && brc_resp_i;
    hit_o     = valid_i && is_posted && bus_ok && resp_ok;
  end
endmodule

// File: rtl/syserr_sticky.sv
module syserr_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    // R10: set has priority over a same-cycle clear
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= 1'b0;
      end else if (set_i[i]) begin
        q <= 1'b1;
      end else if (clr_i[i]) begin
        q <= 1'b0;
      end
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/bridge_syserr_ctrl.sv
module bridge_syserr_ctrl
  import syserr_pkg::*;
#(
  parameter int RETRY_LIMIT = 2**24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_syserr_en,
  input  logic       cmd_perr_resp,
  input  logic       brc_fwd_en,
  input  logic       brc_perr_resp,
  input  logic       dn_syserr_n,
  input  logic       pw_tabort,
  input  logic       pw_mabort,
  input  logic       pw_retry,
  input  logic       pw_done,
  input  logic       perr_valid,
  input  logic [1:0] perr_kind,
  input  logic       perr_on_tgt_bus,
  input  logic       perr_on_init_bus,
  input  logic       perr_self_tgt,
  input  logic       clr_rcvd,
  input  logic       clr_sig,
  output logic       syserr_n,
  output logic       pw_discard,
  output logic       sts_rcvd_syserr,
  output logic       sts_sig_syserr
);
  logic         dn_prev_q;
  logic         dn_event;
  logic         exhaust;
  logic         par_hit;
  cause_t       cause;
  logic         fire;
  logic         syserr_n_q;
  logic         discard_q;
  logic [NUM_STS-1:0] sts_set;
  logic [NUM_STS-1:0] sts_clr;
  logic [NUM_STS-1:0] sts_q;

  // R2: falling-edge detection on the downstream input
  always_ff @(posedge clk) begin
    if (rst) dn_prev_q <= 1'b1;
    else     dn_prev_q <= dn_syserr_n;
  end
  assign dn_event = dn_prev_q && !dn_syserr_n;

  syserr_retry_ctr #(.RETRY_LIMIT(RETRY_LIMIT)) u_retry (
    .clk       (clk),
    .rst       (rst),
    .retry_i   (pw_retry),
    .done_i    (pw_done),
    .exhaust_o (exhaust)
  );

  syserr_perr_qual u_perr (
    .valid_i    (perr_valid),
    .kind_i     (perr_kind),
    .on_tgt_i   (perr_on_tgt_bus),
    .on_init_i  (perr_on_init_bus),
    .self_tgt_i (perr_self_tgt),
    .cmd_resp_i (cmd_perr_resp),
    .brc_resp_i (brc_perr_resp),
    .hit_o      (par_hit)
  );

  always_comb begin
    cause.fwd     = dn_event && brc_fwd_en;
    cause.tabort  = pw_tabort;
    cause.mabort  = pw_mabort;
    cause.discard = exhaust;
    cause.parity  = par_hit;
    fire          = cmd_syserr_en && (|cause);   // R1
  end

  // R11: registered active-low output, one cycle per firing cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      syserr_n_q <= 1'b1;
      discard_q  <= 1'b0;
    end else begin
      syserr_n_q <= !fire;
      discard_q  <= exhaust;
    end
  end

  always_comb begin
    sts_set[STS_RCVD] = cause.fwd;   // R3
    sts_set[STS_SIG]  = fire;        // R4
    sts_clr[STS_RCVD] = clr_rcvd;
    sts_clr[STS_SIG]  = clr_sig;
  end

  syserr_sticky #(.N(NUM_STS)) u_sts (
    .clk   (clk),
    .rst   (rst),
    .set_i (sts_set),
    .clr_i (sts_clr),
    .q_o   (sts_q)
  );

  assign syserr_n        = syserr_n_q;
  assign pw_discard      = discard_q;
  assign sts_rcvd_syserr = sts_q[STS_RCVD];
  assign sts_sig_syserr  = sts_q[STS_SIG];
endmodule

// File: rtl/bridge_syserr_ctrl_chk.sv
module bridge_syserr_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_syserr_en,
  input logic       brc_fwd_en,
  input logic       dn_syserr_n,
  input logic       pw_tabort,
  input logic       pw_mabort,
  input logic       clr_sig,
  input logic       clr_rcvd,
  input logic       syserr_n,
  input logic       pw_discard,
  input logic       sts_rcvd_syserr,
  input logic       sts_sig_syserr
);
  p_gate_r1: assert property (@(posedge clk) disable iff (rst)
    !syserr_n |-> $past(cmd_syserr_en));

  p_fwd_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_syserr_en) && $past(brc_fwd_en) && $past(dn_syserr_n, 2)
     && !$past(dn_syserr_n)) |-> !syserr_n);

  p_sig_r4: assert property (@(posedge clk) disable iff (rst)
    !syserr_n |-> sts_sig_syserr);

  p_abort_r5: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_syserr_en && (pw_tabort || pw_mabort)) |-> !syserr_n);

  p_discard_r6: assert property (@(posedge clk) disable iff (rst)
    (pw_discard && $past(cmd_syserr_en)) |-> !syserr_n);

  p_sticky_sig_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(sts_sig_syserr) && !$past(clr_sig)) |-> sts_sig_syserr);

  p_sticky_rcvd_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(sts_rcvd_syserr) && !$past(clr_rcvd)) |-> sts_rcvd_syserr);
endmodule

bind bridge_syserr_ctrl bridge_syserr_ctrl_chk u_chk (.*);

// File: tb/bridge_syserr_ctrl_bench.sv
module bridge_syserr_ctrl_bench;
  localparam int LIMIT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_syserr_en = 0, cmd_perr_resp = 0, brc_fwd_en = 0, brc_perr_resp = 0;
  logic dn_syserr_n = 1;
  logic pw_tabort = 0, pw_mabort = 0, pw_retry = 0, pw_done = 0;
  logic perr_valid = 0;
  logic [1:0] perr_kind = 2'b00;
  logic perr_on_tgt_bus = 0, perr_on_init_bus = 0, perr_self_tgt = 0;
  logic clr_rcvd = 0, clr_sig = 0;
  logic syserr_n, pw_discard, sts_rcvd_syserr, sts_sig_syserr;

  always #5 clk = ~clk;

  bridge_syserr_ctrl #(.RETRY_LIMIT(LIMIT)) u_bridge_syserr_ctrl (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;
  bit done_flag = 0;
  string cur_req = "R11";

  // behavioural reference
  bit m_n = 1, m_disc = 0, m_rcvd = 0, m_sig = 0, m_prev = 1;
  int m_cnt = 0;

  always @(posedge clk) begin
    bit ev, fwd, disc, par, fire;
    started = 1;
    if (rst) begin
      m_n = 1; m_disc = 0; m_rcvd = 0; m_sig = 0; m_prev = 1; m_cnt = 0;
    end else begin
      ev = m_prev && !dn_syserr_n;
      m_prev = dn_syserr_n;
      fwd = ev && brc_fwd_en;
      disc = pw_retry && !pw_done && (m_cnt + 1 == LIMIT);
      if (pw_done || disc) m_cnt = 0;
      else if (pw_retry) m_cnt = m_cnt + 1;
      par = perr_valid && perr_kind == 2'b01 && perr_on_tgt_bus && !perr_on_init_bus
            && !perr_self_tgt && cmd_perr_resp && brc_perr_resp;
      fire = cmd_syserr_en && (fwd || pw_tabort || pw_mabort || disc || par);
      m_n = !fire;
      m_disc = disc;
      m_sig = fire || (m_sig && !clr_sig);
      m_rcvd = fwd || (m_rcvd && !clr_rcvd);
    end
  end

  task automatic chk1(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done_flag) begin
      chk1("syserr_n", syserr_n, m_n);
      chk1("pw_discard", pw_discard, m_disc);
      chk1("sts_rcvd", sts_rcvd_syserr, m_rcvd);
      chk1("sts_sig", sts_sig_syserr, m_sig);
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done_flag) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      finish_run();
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic strobes_off();
    pw_tabort = 0; pw_mabort = 0; pw_retry = 0; pw_done = 0;
    perr_valid = 0; clr_rcvd = 0; clr_sig = 0;
  endtask

  task automatic parity(logic [1:0] k, logic tg, logic in, logic st, logic cr, logic br);
    perr_valid = 1; perr_kind = k; perr_on_tgt_bus = tg; perr_on_init_bus = in;
    perr_self_tgt = st; cmd_perr_resp = cr; brc_perr_resp = br;
    cyc(); strobes_off(); cyc(2);
  endtask

  initial begin
    cur_req = "R11";
    cyc(3);
    rst = 0;
    cyc(2);
    // R11 reset values, explicit
    chk1("reset syserr_n", syserr_n, 1'b1);
    chk1("reset sts_sig", sts_sig_syserr, 1'b0);

    // R5 aborts
    cur_req = "R5";
    cmd_syserr_en = 1;
    pw_tabort = 1; cyc(); strobes_off(); cyc(2);
    pw_mabort = 1; cyc(); strobes_off(); cyc(2);
    pw_tabort = 1; pw_mabort = 1; cyc(); strobes_off(); cyc(2);

    // R1 gating
    cur_req = "R1";
    cmd_syserr_en = 0;
    pw_tabort = 1; cyc(); strobes_off(); cyc(2);
    cmd_syserr_en = 1;

    // R10 clear
    cur_req = "R10";
    clr_sig = 1; cyc(); strobes_off(); cyc(2);

    // R2/R3 downstream forwarding; held low gives one pulse (R11)
    cur_req = "R2";
    brc_fwd_en = 1;
    dn_syserr_n = 0; cyc(5);
    dn_syserr_n = 1; cyc(2);
    cur_req = "R3";
    brc_fwd_en = 0;
    dn_syserr_n = 0; cyc(2); dn_syserr_n = 1; cyc(2);
    cmd_syserr_en = 0; brc_fwd_en = 1; clr_rcvd = 1; cyc(); strobes_off();
    dn_syserr_n = 0; cyc(2); dn_syserr_n = 1; cyc(2);
    cmd_syserr_en = 1;

    // R10 clear collides with set
    cur_req = "R10";
    clr_rcvd = 1; clr_sig = 1; dn_syserr_n = 0; cyc(); strobes_off(); cyc(2);
    dn_syserr_n = 1;
    clr_rcvd = 1; clr_sig = 1; cyc(); strobes_off(); cyc(2);
    brc_fwd_en = 0;

    // R7 done before the limit
    cur_req = "R7";
    repeat (LIMIT - 1) begin pw_retry = 1; cyc(); end
    strobes_off();
    pw_done = 1; cyc(); strobes_off();
    repeat (LIMIT - 1) begin pw_retry = 1; cyc(); end
    strobes_off(); cyc(2);
    // R6 one more retry reaches limit
    cur_req = "R6";
    pw_retry = 1; cyc(); strobes_off(); cyc(2);
    cur_req = "R7";
    repeat (LIMIT - 1) begin pw_retry = 1; cyc(); end
    pw_done = 1; cyc(); strobes_off(); cyc(2);
    cur_req = "R6";
    repeat (LIMIT) begin pw_retry = 1; cyc(); end
    strobes_off(); cyc(2);
    cmd_syserr_en = 0;
    repeat (LIMIT) begin pw_retry = 1; cyc(); end
    strobes_off(); cyc(2);
    cmd_syserr_en = 1;

    // R8 posted write parity qualification
    cur_req = "R8";
    parity(2'b01, 1, 0, 0, 1, 1);
    parity(2'b01, 0, 0, 0, 1, 1);
    parity(2'b01, 1, 1, 0, 1, 1);
    parity(2'b01, 1, 0, 1, 1, 1);
    parity(2'b01, 1, 0, 0, 0, 1);
    parity(2'b01, 1, 0, 0, 1, 0);
    // R9 other transaction kinds
    cur_req = "R9";
    parity(2'b00, 1, 0, 0, 1, 1);
    parity(2'b10, 1, 0, 0, 1, 1);
    parity(2'b11, 1, 0, 0, 1, 1);
    parity(2'b10, 0, 1, 0, 0, 0);

    // R11 back-to-back causes and reset
    cur_req = "R11";
    pw_tabort = 1; cyc(); strobes_off(); pw_mabort = 1; cyc(); strobes_off(); cyc(3);
    rst = 1; cyc(2); rst = 0; cyc(2);
    chk1("post-reset sts_sig", sts_sig_syserr, 1'b0);
    finish_run();
  end
endmodule